// File: doc/BRIEF.md
# Table Pointer Read/Write Unit

This block moves single bytes between program memory and an 8-bit holding latch. The program-memory byte address comes from a 21-bit pointer register. A caller presents a 16-bit instruction word and pulses a start strobe. If the word is one of the eight table transfer opcodes, the unit runs a fixed two-cycle access. During that access it adjusts the pointer according to the addressing mode carried in the low opcode bits.

A read copies the addressed program-memory byte into the latch. A write drives the latch contents onto the memory write port together with a one-cycle write strobe. The pointer and the latch can each be preloaded while the unit is idle, and both can be read back at all times. No status flags are produced. Only a busy level and a completion pulse leave the block.

Top module: `tblx_unit`

## Requirements
- R1: A start pulse is accepted only while idle and only when `instr[15:3]` equals binary 0000000000001 (words 0x0008 to 0x000F). `instr[2]`=0 selects a read and 1 selects a write. Any other word leaves busy low and the pointer unchanged.
- R2: Mode `instr[1:0]`=00 accesses the current pointer value and leaves the pointer unchanged.
- R3: Mode 01 accesses the current pointer value, then leaves the pointer one higher.
- R4: Mode 10 accesses the current pointer value, then leaves the pointer one lower.
- R5: Mode 11 increments the pointer first and uses the incremented value both for the access and as the new pointer.
- R6: Pointer arithmetic wraps modulo 2^21: 0x1FFFFF+1 gives 0, and 0-1 gives 0x1FFFFF.
- R7: After the accepting clock edge, busy is high for exactly two cycles. done is high in the second of those cycles only. The pointer update is visible from the first busy cycle on and stays stable through the second.
- R8: A read asserts `memRdEn` in the first busy cycle with `memAddr` set to the access address. The latch holds `memRdData` from the second busy cycle onward.
- R9: A write asserts `memWrEn` in the first busy cycle with `memAddr` set to the access address and `memWrData` equal to the latch. The latch is unchanged. At most one of the two strobes is high, and only while busy.
- R10: A start pulse that arrives while busy is ignored.
- R11: `ptrLoad` loads `ptrLoadVal` into the pointer when idle. It is ignored while busy. An accepted start in the same cycle takes priority over it.
- R12: `latchLoad` loads `latchLoadVal` into the latch when idle. It is ignored while busy and when a start is accepted in the same cycle.
- R13: After reset the pointer and the latch are 0, busy and done are low, and neither memory strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin executing `instr` |
| instr | input | 16 | Instruction word |
| ptrLoad | input | 1 | Preload the pointer |
| ptrLoadVal | input | 21 | Pointer preload value |
| latchLoad | input | 1 | Preload the latch |
| latchLoadVal | input | 8 | Latch preload value |
| memRdData | input | 8 | Byte returned by program memory |
| ptrVal | output | 21 | Pointer readback |
| latchVal | output | 8 | Latch readback |
| memAddr | output | 21 | Program-memory byte address |
| memRdEn | output | 1 | Read strobe |
| memWrEn | output | 1 | Write strobe |
| memWrData | output | 8 | Byte to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer completes this cycle |

## Verification
All four modes are swept in both directions, starting from pointer values that include zero, one, the all-ones top address and two mid-range values. This separates the old-versus-new address choice from the step direction, and it exposes any carry that fails to wrap at 21 bits. Memory read data is an arithmetic function of the address, so a byte latched from the wrong address is caught. During every access the bench also drives stray start, pointer-load and latch-load pulses, which tells a correct idle-only gate apart from one that leaks. A set of neighbouring non-table words checks that decoding rejects every opcode outside the eight valid ones.

// File: rtl/tblx_pkg.sv
package tblx_pkg;
  localparam int PTR_W   = 21;
  localparam int DATA_W  = 8;
  localparam int INSTR_W = 16;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_POST_INC = 2'b01,
    STEP_POST_DEC = 2'b10,
    STEP_PRE_INC  = 2'b11
  } stepMode_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_ACCESS = 2'b01,
    ST_FINISH = 2'b10
  } xferState_t;

  typedef struct packed {
    logic      captureOp;
    stepMode_t stepMode;
    logic      rdStrobe;
    logic      wrStrobe;
    logic      latchCapture;
    logic      ptrLoadEn;
    logic      latchLoadEn;
  } ctrlStrobe_t;
endpackage

// File: rtl/tblx_decode.sv
module tblx_decode
  import tblx_pkg::*;
#(
  parameter int INSTR_WIDTH = INSTR_W
) (
  input  logic [INSTR_WIDTH-1:0] instr,
  output logic                   isTable,
  output logic                   isWrite,
  output stepMode_t              stepMode
);
  localparam int HI_W = INSTR_WIDTH - 3;
  localparam logic [HI_W-1:0] TABLE_PREFIX = HI_W'(1);

  always_comb begin
    isTable  = (instr[INSTR_WIDTH-1:3] == TABLE_PREFIX);
    isWrite  = instr[2];
    stepMode = stepMode_t'(instr[1:0]);
  end
endmodule

// File: rtl/tblx_ctrl.sv
module tblx_ctrl
  import tblx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        isTable,
  input  logic        isWrite,
  input  stepMode_t   stepMode,
  input  logic        ptrLoad,
  input  logic        latchLoad,
  output ctrlStrobe_t st,
  output logic        busy,
  output logic        done
);
  xferState_t state, stateNext;
  logic       writeQ;
  logic       accept;

  assign accept = (state == ST_IDLE) && start && isTable;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:   if (accept) stateNext = ST_ACCESS;
      ST_ACCESS: stateNext = ST_FINISH;
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      writeQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (accept) writeQ <= isWrite;
    end
  end

  always_comb begin
    st.captureOp    = accept;
    st.stepMode     = stepMode;
    st.rdStrobe     = (state == ST_ACCESS) && !writeQ;
    st.wrStrobe     = (state == ST_ACCESS) && writeQ;
    st.latchCapture = (state == ST_ACCESS) && !writeQ;
    st.ptrLoadEn    = (state == ST_IDLE) && ptrLoad && !accept;
    st.latchLoadEn  = (state == ST_IDLE) && latchLoad && !accept;
    busy            = (state != ST_IDLE);
    done            = (state == ST_FINISH);
  end
endmodule

// File: rtl/tblx_datapath.sv
module tblx_datapath
  import tblx_pkg::*;
#(
  parameter int PTR_WIDTH  = PTR_W,
  parameter int DATA_WIDTH = DATA_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           st,
  input  logic [PTR_WIDTH-1:0]  ptrLoadVal,
  input  logic [DATA_WIDTH-1:0] latchLoadVal,
  input  logic [DATA_WIDTH-1:0] memRdData,
  output logic [PTR_WIDTH-1:0]  ptrVal,
  output logic [DATA_WIDTH-1:0] latchVal,
  output logic [PTR_WIDTH-1:0]  memAddr
);
  localparam logic [PTR_WIDTH-1:0] ONE = PTR_WIDTH'(1);

  logic [PTR_WIDTH-1:0] ptrQ, accAddrQ, ptrNext, ptrInc, ptrDec;
  logic [DATA_WIDTH-1:0] latchQ;

  assign ptrInc = ptrQ + ONE;
  assign ptrDec = ptrQ - ONE;

  always_comb begin
    case (st.stepMode)
      STEP_POST_INC, STEP_PRE_INC: ptrNext = ptrInc;
      STEP_POST_DEC:               ptrNext = ptrDec;
      default:                     ptrNext = ptrQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ     <= '0;
      accAddrQ <= '0;
      latchQ   <= '0;
    end else begin
      if (st.ptrLoadEn) begin
        ptrQ <= ptrLoadVal;
      end else if (st.captureOp) begin
        ptrQ     <= ptrNext;
        accAddrQ <= (st.stepMode == STEP_PRE_INC) ? ptrInc : ptrQ;
      end
      if (st.latchLoadEn) latchQ <= latchLoadVal;
      else if (st.latchCapture) latchQ <= memRdData;
    end
  end

  assign ptrVal   = ptrQ;
  assign latchVal = latchQ;
  assign memAddr  = accAddrQ;
endmodule

// File: rtl/tblx_unit.sv
module tblx_unit
  import tblx_pkg::*;
#(
  parameter int PTR_WIDTH   = PTR_W,
  parameter int DATA_WIDTH  = DATA_W,
  parameter int INSTR_WIDTH = INSTR_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [INSTR_WIDTH-1:0] instr,
  input  logic                   ptrLoad,
  input  logic [PTR_WIDTH-1:0]   ptrLoadVal,
  input  logic                   latchLoad,
  input  logic [DATA_WIDTH-1:0]  latchLoadVal,
  input  logic [DATA_WIDTH-1:0]  memRdData,
  output logic [PTR_WIDTH-1:0]   ptrVal,
  output logic [DATA_WIDTH-1:0]  latchVal,
  output logic [PTR_WIDTH-1:0]   memAddr,
  output logic                   memRdEn,
  output logic                   memWrEn,
  output logic [DATA_WIDTH-1:0]  memWrData,
  output logic                   busy,
  output logic                   done
);
  logic        isTable, isWrite;
  stepMode_t   stepMode;
  ctrlStrobe_t st;

  tblx_decode #(.INSTR_WIDTH(INSTR_WIDTH)) u_decode (
    .instr(instr), .isTable(isTable), .isWrite(isWrite), .stepMode(stepMode)
  );

  tblx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .isTable(isTable),
    .isWrite(isWrite), .stepMode(stepMode), .ptrLoad(ptrLoad),
    .latchLoad(latchLoad), .st(st), .busy(busy), .done(done)
  );

  tblx_datapath #(.PTR_WIDTH(PTR_WIDTH), .DATA_WIDTH(DATA_WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .ptrLoadVal(ptrLoadVal),
    .latchLoadVal(latchLoadVal), .memRdData(memRdData), .ptrVal(ptrVal),
    .latchVal(latchVal), .memAddr(memAddr)
  );

  assign memRdEn   = st.rdStrobe;
  assign memWrEn   = st.wrStrobe;
  assign memWrData = latchVal;
endmodule

// File: rtl/tblx_unit_chk.sv
module tblx_unit_chk #(
  parameter int PTR_WIDTH  = 21,
  parameter int DATA_WIDTH = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [PTR_WIDTH-1:0]  ptrVal,
  input logic [DATA_WIDTH-1:0] latchVal,
  input logic                  memRdEn,
  input logic                  memWrEn,
  input logic                  busy,
  input logic                  done
);
  AST_BUSY_SECOND: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> (busy && done)); // R7
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!busy && !done)); // R7
  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy); // R7
  AST_PTR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(ptrVal)); // R7
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn)); // R9
  AST_STROBE_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn || memWrEn) |-> (busy && !done)); // R9
  AST_WRITE_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> $stable(latchVal)); // R9
endmodule

bind tblx_unit tblx_unit_chk #(.PTR_WIDTH(PTR_WIDTH), .DATA_WIDTH(DATA_WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .ptrVal(ptrVal), .latchVal(latchVal),
  .memRdEn(memRdEn), .memWrEn(memWrEn), .busy(busy), .done(done)
);

// File: tb/tblx_unit_tb.sv
module tblx_unit_tb;
  localparam int CLK_P = 10;
  localparam int PW = 21;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [15:0] instr = '0;
  logic ptrLoad = 1'b0;
  logic [PW-1:0] ptrLoadVal = '0;
  logic latchLoad = 1'b0;
  logic [DW-1:0] latchLoadVal = '0;
  logic [DW-1:0] memRdData;
  logic [PW-1:0] ptrVal, memAddr;
  logic [DW-1:0] latchVal, memWrData;
  logic memRdEn, memWrEn, busy, done;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [DW-1:0] memModel(input logic [PW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {3'b000, a[20:16]} ^ 8'h5A;
  endfunction

  assign memRdData = memModel(memAddr);

  tblx_unit u_dut (
    .clk(clk), .rstN(rstN), .start(start), .instr(instr), .ptrLoad(ptrLoad),
    .ptrLoadVal(ptrLoadVal), .latchLoad(latchLoad), .latchLoadVal(latchLoadVal),
    .memRdData(memRdData), .ptrVal(ptrVal), .latchVal(latchVal),
    .memAddr(memAddr), .memRdEn(memRdEn), .memWrEn(memWrEn),
    .memWrData(memWrData), .busy(busy), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic wr, input logic [1:0] mode, input logic [PW-1:0] p0,
                       input logic [DW-1:0] l0);
    logic [PW-1:0] addrExp, ptrExp;
    logic [DW-1:0] latchExp;
    @(negedge clk); ptrLoad = 1'b1; ptrLoadVal = p0; latchLoad = 1'b1; latchLoadVal = l0;
    @(negedge clk); ptrLoad = 1'b0; latchLoad = 1'b0;
    check("R11 preload ptr", 32'(ptrVal), 32'(p0));
    check("R12 preload latch", 32'(latchVal), 32'(l0));
    case (mode)
      2'b00: begin addrExp = p0; ptrExp = p0; end
      2'b01: begin addrExp = p0; ptrExp = p0 + 1'b1; end
      2'b10: begin addrExp = p0; ptrExp = p0 - 1'b1; end
      default: begin addrExp = p0 + 1'b1; ptrExp = p0 + 1'b1; end
    endcase
    latchExp = wr ? l0 : memModel(addrExp);
    start = 1'b1; instr = {13'd1, wr, mode};
    @(negedge clk);
    // first busy cycle; stray inputs that must be ignored (R10, R11, R12)
    start = 1'b1; instr = {13'd1, ~wr, ~mode};
    ptrLoad = 1'b1; ptrLoadVal = ~p0; latchLoad = 1'b1; latchLoadVal = ~l0;
    check("R7 busy c1", 32'(busy), 32'd1);
    check("R7 done c1", 32'(done), 32'd0);
    check("R2 R3 R4 R5 R6 addr", 32'(memAddr), 32'(addrExp));
    check("R2 R3 R4 R5 R6 ptr", 32'(ptrVal), 32'(ptrExp));
    check("R8 rd strobe", 32'(memRdEn), 32'(!wr));
    check("R9 wr strobe", 32'(memWrEn), 32'(wr));
    if (wr) check("R9 wr data", 32'(memWrData), 32'(l0));
    @(negedge clk);
    start = 1'b0; ptrLoad = 1'b0; latchLoad = 1'b0;
    check("R7 busy c2", 32'(busy), 32'd1);
    check("R7 done c2", 32'(done), 32'd1);
    check("R7 ptr stable c2", 32'(ptrVal), 32'(ptrExp));
    check("R8 R9 latch c2", 32'(latchVal), 32'(latchExp));
    check("R9 no strobe c2", 32'(memRdEn | memWrEn), 32'd0);
    @(negedge clk);
    check("R7 R10 idle after", 32'(busy | done), 32'd0);
    check("R10 R11 ptr after", 32'(ptrVal), 32'(ptrExp));
    check("R12 latch after", 32'(latchVal), 32'(latchExp));
  endtask

  initial begin
    #(CLK_P * 100000);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [PW-1:0] ptrs [5];
    logic [15:0] bad [8];
    ptrs[0] = 21'h000000; ptrs[1] = 21'h000001; ptrs[2] = 21'h1FFFFF;
    ptrs[3] = 21'h0ABCDE; ptrs[4] = 21'h100000;
    bad[0] = 16'h0000; bad[1] = 16'h0007; bad[2] = 16'h0010; bad[3] = 16'h0018;
    bad[4] = 16'h8008; bad[5] = 16'h1008; bad[6] = 16'h0108; bad[7] = 16'h0048;
    repeat (3) @(negedge clk);
    // R13 reset state
    check("R13 ptr", 32'(ptrVal), 32'd0);
    check("R13 latch", 32'(latchVal), 32'd0);
    check("R13 busy/done", 32'({busy, done}), 32'd0);
    check("R13 strobes", 32'({memRdEn, memWrEn}), 32'd0);
    rstN = 1'b1;
    for (int w = 0; w < 2; w++)
      for (int m = 0; m < 4; m++)
        for (int i = 0; i < 5; i++)
          runOp(w[0], m[1:0], ptrs[i], 8'(8'h3C + 17 * i + 5 * m));
    // R1 rejected opcodes
    for (int b = 0; b < 8; b++) begin
      @(negedge clk); ptrLoad = 1'b1; ptrLoadVal = 21'h012345;
      @(negedge clk); ptrLoad = 1'b0; start = 1'b1; instr = bad[b];
      @(negedge clk); start = 1'b0;
      check("R1 reject busy", 32'(busy), 32'd0);
      check("R1 reject ptr", 32'(ptrVal), 32'h012345);
      check("R1 reject strobes", 32'({memRdEn, memWrEn}), 32'd0);
    end
    // R11 start wins over simultaneous pointer load
    @(negedge clk); ptrLoad = 1'b1; ptrLoadVal = 21'h000100;
    @(negedge clk); start = 1'b1; instr = 16'h0009; ptrLoadVal = 21'h0F0F0F;
    @(negedge clk); start = 1'b0; ptrLoad = 1'b0;
    check("R11 start priority ptr", 32'(ptrVal), 32'h000101);
    check("R11 start priority addr", 32'(memAddr), 32'h000100);
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule